// File: doc/BRIEF.md
# 16-bit Multi-Cycle CPU Core

This block is a small register-based processor. It executes one instruction at a time, and each instruction walks through four named phases. It has eight 16-bit general registers (R0 to R7) and three special registers: a program counter, a stack pointer and a four-bit status word. It reaches a byte-addressed 64 KB space through a synchronous word port. The port drives word-aligned addresses, and read data returns in the cycle after the request. Stores whose effective address falls in the top 256-byte page leave RAM untouched and are turned into single-cycle character strobes.

The sequencer has five states:

- **PH_FETCH** drives the read at PC and always moves to PH_DECODE.
- **PH_DECODE** captures the instruction word and always moves to PH_EXECUTE.
- **PH_EXECUTE** computes results, effective addresses and stack traffic. It moves to PH_STORE, or to PH_HALT when the opcode is the halt code.
- **PH_STORE** writes registers and flags and updates PC and SP. It always returns to PH_FETCH.
- **PH_HALT** is absorbing and is left only by reset.

Top module: `mini_cpu16`

## Requirements
- R1: While reset is held and in the first cycle after it, `halted` is 0 and `flags` is 0. The first cycle after reset is a read at address 0x0000. SP starts at 0xFFFF.
- R2: A non-branching instruction takes exactly four cycles and advances PC by 2, so consecutive fetch reads are four cycles apart at addresses two bytes apart.
- R3: The instruction word has these fields:
  - opcode in [15:12]
  - Rd in [11:9]
  - Rs in [8:6]
  - Rt in [5:3]
  - a signed immediate in [5:0]

  The opcodes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOT=5, SHL=6, SHR=7, LD=8, ST=9, JMP=A, LDI=B, JZ=C, JNZ=D, CALL/RET=E (bit 0 set selects RET) and HLT=F.
- R4: LDI writes the 6-bit immediate, sign-extended to 16 bits, into Rd.
- R5: ADD and SUB compute Rd = Rs op Rt. `flags` is {V,C,Z,N} on bits 3..0. On ADD, C is the carry out. On SUB, C is the borrow (Rs < Rt unsigned). V is the signed overflow.
- R6: AND, OR, XOR and NOT (Rd = ~Rs) clear C and V and set Z and N from the result.
- R7: SHL and SHR shift Rs by one place into Rd. C takes the bit shifted out and V is cleared.
- R8: LD and ST use the address Rs + sext(imm), with bit 0 dropped on the port. ST writes Rd. Neither changes the flags.
- R9: A ST whose address is 0xFF00 or higher raises `char_valid` for one cycle with Rd[7:0] on `char_data` and issues no memory write.
- R10: JMP, JZ (taken when Z=1) and JNZ (taken when Z=0) branch to PC + 2 + 2·sext(imm). When not taken they fall through to PC + 2.
- R11: CALL first lowers SP by 2. It writes PC+2 to the lowered SP (aligned), then jumps to Rs. RET reads PC from SP and raises SP by 2, so a second call after a return pushes to the same address again.
- R12: After HLT, `halted` stays 1 and no further read, write or character strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_rd | output | 1 | Read request; data is returned the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| char_valid | output | 1 | Character strobe for the I/O page |
| char_data | output | 8 | Character byte |
| flags | output | 4 | Status {V,C,Z,N} |
| halted | output | 1 | Core has stopped |

## Verification
The two actions that share a cycle are the stack-pointer decrement and the stack write of CALL, both done in PH_EXECUTE. The write must land at the already-lowered pointer, not at the old one. This case is provoked by two calls in a row to the same subroutine, each one returned from. The bench judges it by the address and data seen on the memory port. Both pushes must land at 0xFFFC with the right return address. Landing at 0xFFFE, or at different addresses for the two calls, shows either a stale pointer or an unbalanced RET.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
    localparam int XLEN      = 16;
    localparam int REG_COUNT = 8;
    localparam int IMM_W     = 6;
    localparam logic [7:0]  IO_PAGE = 8'hFF;
    localparam logic [15:0] SP_INIT = 16'hFFFF;
    localparam logic [15:0] PC_INIT = 16'h0000;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR,
        OP_LD, OP_ST, OP_JMP, OP_LDI, OP_JZ, OP_JNZ, OP_CALLRET, OP_HLT
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH, PH_DECODE, PH_EXECUTE, PH_STORE, PH_HALT
    } phase_e;

    typedef enum logic [2:0] {
        AO_ADD, AO_SUB, AO_AND, AO_OR, AO_XOR, AO_NOT, AO_SHL, AO_SHR
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
    } flags_t;
endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output flags_t         f
);
    logic [W:0] sum;
    logic [W:0] dif;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        dif = {1'b0, a} - {1'b0, b};
        y   = '0;
        f   = '0;
        unique case (op)
            AO_ADD: begin
                y   = sum[W-1:0];
                f.c = sum[W];
                f.v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            AO_SUB: begin
                y   = dif[W-1:0];
                f.c = dif[W];
                f.v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            AO_AND: y = a & b;
            AO_OR:  y = a | b;
            AO_XOR: y = a ^ b;
            AO_NOT: y = ~a;
            AO_SHL: begin
                y   = {a[W-2:0], 1'b0};
                f.c = a[W-1];
            end
            AO_SHR: begin
                y   = {1'b0, a[W-1:1]};
                f.c = a[0];
            end
            default: y = '0;
        endcase
        f.z = (y == '0);
        f.n = y[W-1];
    end
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter  int W  = 16,
    parameter  int N  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];

    // R3: a writeback is visible in the named register one cycle later
    assert_wb_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
    import mcpu_pkg::*;
#(
    parameter  int W    = XLEN,
    parameter  int NREG = REG_COUNT,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [W-1:0]  mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          char_valid,
    output logic [7:0]    char_data,
    output logic [3:0]    flags,
    output logic          halted,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [W-1:0]  rf_wdata,
    output logic [AW-1:0] rf_ra_a,
    output logic [AW-1:0] rf_ra_b,
    output logic [AW-1:0] rf_ra_c,
    input  logic [W-1:0]  rf_rd_a,
    input  logic [W-1:0]  rf_rd_b,
    input  logic [W-1:0]  rf_rd_c,
    output alu_op_e       alu_op,
    output logic [W-1:0]  alu_a,
    output logic [W-1:0]  alu_b,
    input  logic [W-1:0]  alu_y,
    input  flags_t        alu_f
);
    phase_e       state_q, state_d;
    logic [W-1:0] pc_q, sp_q, ir_q, res_q;
    flags_t       flags_q, fres_q;

    opcode_e      opc;
    logic [W-1:0] imm_sx, eaddr, pc_next, br_tgt, sp_dn;
    logic         is_io, is_ret, take_br, is_alu;

    // field decode of the held instruction word
    always_comb begin
        opc     = opcode_e'(ir_q[15:12]);
        imm_sx  = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        eaddr   = rf_rd_a + imm_sx;
        is_io   = (eaddr[W-1:W-8] == IO_PAGE);
        pc_next = pc_q + W'(2);
        br_tgt  = pc_next + (imm_sx << 1);
        sp_dn   = sp_q - W'(2);
        is_ret  = ir_q[0];
        is_alu  = ~ir_q[15];
        take_br = (opc == OP_JMP) || (opc == OP_JZ && flags_q.z)
               || (opc == OP_JNZ && !flags_q.z);
    end

    assign rf_ra_a = ir_q[8:6];
    assign rf_ra_b = ir_q[5:3];
    assign rf_ra_c = ir_q[11:9];
    assign flags   = flags_q;
    assign halted  = (state_q == PH_HALT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_FETCH;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        char_valid = 1'b0;
        char_data  = '0;
        rf_we      = 1'b0;
        rf_waddr   = ir_q[11:9];
        rf_wdata   = '0;
        alu_op     = alu_op_e'(ir_q[14:12]);
        alu_a      = rf_rd_a;
        alu_b      = rf_rd_b;
        unique case (state_q)
            PH_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = {pc_q[W-1:1], 1'b0};
                state_d  = PH_DECODE;
            end
            PH_DECODE: state_d = PH_EXECUTE;
            PH_EXECUTE: begin
                state_d = (opc == OP_HLT) ? PH_HALT : PH_STORE;
                case (opc)
                    OP_LD: begin
                        mem_rd   = 1'b1;
                        mem_addr = {eaddr[W-1:1], 1'b0};
                    end
                    OP_ST: begin
                        if (is_io) begin
                            char_valid = 1'b1;
                            char_data  = rf_rd_c[7:0];
                        end else begin
                            mem_wr    = 1'b1;
                            mem_addr  = {eaddr[W-1:1], 1'b0};
                            mem_wdata = rf_rd_c;
                        end
                    end
                    OP_CALLRET: begin
                        if (is_ret) begin
                            mem_rd   = 1'b1;
                            mem_addr = {sp_q[W-1:1], 1'b0};
                        end else begin
                            mem_wr    = 1'b1;
                            mem_addr  = {sp_dn[W-1:1], 1'b0};
                            mem_wdata = pc_next;
                        end
                    end
                    default: ;
                endcase
            end
            PH_STORE: begin
                state_d = PH_FETCH;
                if (is_alu) begin
                    rf_we    = 1'b1;
                    rf_wdata = res_q;
                end else if (opc == OP_LD) begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                end else if (opc == OP_LDI) begin
                    rf_we    = 1'b1;
                    rf_wdata = imm_sx;
                end
            end
            PH_HALT: state_d = PH_HALT;
            default: state_d = PH_FETCH;
        endcase
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= PC_INIT;
            sp_q    <= SP_INIT;
            ir_q    <= '0;
            res_q   <= '0;
            flags_q <= '0;
            fres_q  <= '0;
        end else begin
            case (state_q)
                PH_DECODE: ir_q <= mem_rdata;
                PH_EXECUTE: begin
                    res_q  <= alu_y;
                    fres_q <= alu_f;
                    if (opc == OP_CALLRET && !is_ret) sp_q <= sp_dn;
                end
                PH_STORE: begin
                    if (is_alu) flags_q <= fres_q;
                    if (opc == OP_CALLRET) begin
                        if (is_ret) begin
                            pc_q <= mem_rdata;
                            sp_q <= sp_q + W'(2);
                        end else begin
                            pc_q <= rf_rd_a;
                        end
                    end else if (take_br) begin
                        pc_q <= br_tgt;
                    end else begin
                        pc_q <= pc_next;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_single_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_io_not_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_valid && mem_wr));
    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr && !char_valid));
    assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FETCH) |=> (state_q == PH_DECODE));
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_STORE && !take_br && opc != OP_CALLRET)
        |=> (pc_q == $past(pc_q) + W'(2)));
    assert_sp_odd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q[0]);
    assert_push_lowers_sp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && state_q == PH_EXECUTE && opc == OP_CALLRET)
        |=> (sp_q == $past(sp_q) - W'(2)));
endmodule

// File: rtl/mini_cpu16.sv
module mini_cpu16
    import mcpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        char_valid,
    output logic [7:0]  char_data,
    output logic [3:0]  flags,
    output logic        halted
);
    localparam int AW = $clog2(REG_COUNT);

    logic          rf_we;
    logic [AW-1:0] rf_waddr, rf_ra_a, rf_ra_b, rf_ra_c;
    logic [XLEN-1:0] rf_wdata, rf_rd_a, rf_rd_b, rf_rd_c;
    alu_op_e       alu_op;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    flags_t        alu_f;

    mcpu_regfile #(.W(XLEN), .N(REG_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .ra_a(rf_ra_a), .ra_b(rf_ra_b), .ra_c(rf_ra_c),
        .rd_a(rf_rd_a), .rd_b(rf_rd_b), .rd_c(rf_rd_c)
    );

    mcpu_alu #(.W(XLEN)) u_alu (
        .op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y), .f(alu_f)
    );

    mcpu_ctrl #(.W(XLEN), .NREG(REG_COUNT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .char_valid(char_valid), .char_data(char_data),
        .flags(flags), .halted(halted),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_ra_a(rf_ra_a), .rf_ra_b(rf_ra_b), .rf_ra_c(rf_ra_c),
        .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .rf_rd_c(rf_rd_c),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .alu_y(alu_y), .alu_f(alu_f)
    );
endmodule

// File: tb/mini_cpu16_bench.sv
module mini_cpu16_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, char_valid, halted;
    logic [7:0]  char_data;
    logic [3:0]  flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    mini_cpu16 u_mini_cpu16 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .char_valid(char_valid), .char_data(char_data), .flags(flags),
        .halted(halted)
    );

    logic [15:0] ram [0:32767];
    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr[15:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr[15:1]];
    end

    // port monitor, sampled at the falling edge
    int cyc, rd_cnt, wr_cnt, ch_cnt;
    int          rd_cyc  [0:7];
    logic [15:0] rd_addr [0:7];
    logic [15:0] wr_addr [0:15];
    logic [15:0] wr_data [0:15];
    logic [7:0]  ch      [0:15];
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (mem_rd) begin
                if (rd_cnt < 8) begin rd_cyc[rd_cnt] = cyc; rd_addr[rd_cnt] = mem_addr; end
                rd_cnt++;
            end
            if (mem_wr) begin
                if (wr_cnt < 16) begin wr_addr[wr_cnt] = mem_addr; wr_data[wr_cnt] = mem_wdata; end
                wr_cnt++;
            end
            if (char_valid) begin
                if (ch_cnt < 16) ch[ch_cnt] = char_data;
                ch_cnt++;
            end
        end
    end

    int errors = 0;
    int checks = 0;
    logic [15:0] prog [$];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(input logic [3:0] op, input int rd, input int rs, input int rt);
        return {op, 3'(rd), 3'(rs), 3'(rt), 3'b000};
    endfunction
    function automatic logic [15:0] ri(input logic [3:0] op, input int rd, input int rs, input int imm);
        return {op, 3'(rd), 3'(rs), 6'(imm)};
    endfunction
    localparam logic [15:0] HLT = 16'hF000;

    // word 0 jumps over the data area to byte 32 where the program sits
    task automatic boot();
        for (int i = 0; i < 128; i++) ram[i] = '0;
        for (int i = 32640; i < 32768; i++) ram[i] = '0;
        ram[0] = ri(4'hA, 0, 0, 15);
        foreach (prog[i]) ram[16 + i] = prog[i];
        prog.delete();
    endtask

    task automatic reset_cpu();
        rst_n = 1'b0;
        cyc = 0; rd_cnt = 0; wr_cnt = 0; ch_cnt = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        for (int n = 0; n < 3000 && !halted; n++) @(negedge clk);
        @(negedge clk);
        chk(req, 16'(halted), 16'h1);
    endtask

    task automatic t_reset();
        prog.push_back(HLT);
        boot();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 halted in reset", 16'(halted), 16'h0);
        chk("R1 flags in reset", 16'(flags), 16'h0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first read", 16'(mem_rd), 16'h1);
        chk("R1 first address", mem_addr, 16'h0000);
        chk("R1 halted after reset", 16'(halted), 16'h0);
        wait_halt("R12 halt reached");
    endtask

    task automatic t_ldi_add();   // R3 R4 R5 R2
        prog.push_back(ri(4'hB, 1, 0, -3));
        prog.push_back(ri(4'hB, 2, 0, 5));
        prog.push_back(rr(4'h0, 3, 1, 2));
        prog.push_back(ri(4'h9, 3, 0, 16));
        prog.push_back(ri(4'h9, 1, 0, 18));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R3 ldi/add run");
        chk("R5 add result", ram[8], 16'h0002);
        chk("R4 ldi sign extension", ram[9], 16'hFFFD);
        chk("R5 add carry flags", 16'(flags), 16'h4);
        chk("R2 fetch addr 0", rd_addr[0], 16'h0000);
        chk("R2 fetch addr 1", rd_addr[1], 16'h0020);
        chk("R2 fetch addr 2", rd_addr[2], 16'h0022);
        chk("R2 cadence 0-1", 16'(rd_cyc[1] - rd_cyc[0]), 16'd4);
        chk("R2 cadence 1-2", 16'(rd_cyc[2] - rd_cyc[1]), 16'd4);
    endtask

    task automatic t_sub_borrow();
        prog.push_back(ri(4'hB, 1, 0, 2));
        prog.push_back(ri(4'hB, 2, 0, 3));
        prog.push_back(rr(4'h1, 3, 1, 2));
        prog.push_back(ri(4'h9, 3, 0, 2));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R5 sub run");
        chk("R5 sub result", ram[1], 16'hFFFF);
        chk("R5 sub borrow flags", 16'(flags), 16'h5);
    endtask

    task automatic t_overflow();
        prog.push_back(ri(4'hB, 1, 0, -1));
        prog.push_back(rr(4'h7, 1, 1, 0));
        prog.push_back(ri(4'h9, 1, 0, 2));
        prog.push_back(ri(4'hB, 4, 0, 1));
        prog.push_back(rr(4'h0, 2, 1, 4));
        prog.push_back(ri(4'h9, 2, 0, 4));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R5 overflow run");
        chk("R7 shr of all ones", ram[1], 16'h7FFF);
        chk("R5 overflow sum", ram[2], 16'h8000);
        chk("R5 overflow flags", 16'(flags), 16'h9);
    endtask

    task automatic t_shift(input bit left);
        prog.push_back(ri(4'hB, 1, 0, left ? -16 : -15));
        prog.push_back(rr(left ? 4'h6 : 4'h7, 2, 1, 0));
        prog.push_back(ri(4'h9, 2, 0, 2));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R7 shift run");
        chk("R7 shift result", ram[1], left ? 16'hFFE0 : 16'h7FF8);
        chk("R7 shift carry flags", 16'(flags), left ? 16'h5 : 16'h4);
    endtask

    task automatic t_logic();
        prog.push_back(ri(4'hB, 1, 0, -16));
        prog.push_back(ri(4'hB, 2, 0, 15));
        prog.push_back(rr(4'h4, 3, 1, 2));
        prog.push_back(rr(4'h2, 4, 1, 2));
        prog.push_back(rr(4'h3, 5, 1, 2));
        prog.push_back(rr(4'h5, 6, 5, 0));
        prog.push_back(ri(4'h9, 3, 0, 2));
        prog.push_back(ri(4'h9, 4, 0, 4));
        prog.push_back(ri(4'h9, 5, 0, 6));
        prog.push_back(ri(4'h9, 6, 0, 8));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R6 logic run");
        chk("R6 xor", ram[1], 16'hFFFF);
        chk("R6 and", ram[2], 16'h0000);
        chk("R6 or", ram[3], 16'hFFFF);
        chk("R6 not", ram[4], 16'h0000);
        chk("R6 not flags", 16'(flags), 16'h2);
    endtask

    task automatic t_mmio();
        prog.push_back(ri(4'hB, 1, 0, -1));
        prog.push_back(ri(4'hB, 2, 0, 31));
        prog.push_back(ri(4'hB, 3, 0, -5));
        prog.push_back(ri(4'h9, 2, 1, -1));
        prog.push_back(ri(4'hB, 4, 0, -1));
        for (int k = 0; k < 8; k++) prog.push_back(rr(4'h6, 4, 4, 0));
        prog.push_back(ri(4'h9, 3, 4, 0));
        prog.push_back(ri(4'h9, 3, 4, -2));
        prog.push_back(ri(4'h9, 2, 0, 4));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R9 io run");
        chk("R9 char count", 16'(ch_cnt), 16'd2);
        chk("R9 char 0", 16'(ch[0]), 16'h001F);
        chk("R9 char at page base", 16'(ch[1]), 16'h00FB);
        chk("R9 ram writes", 16'(wr_cnt), 16'd2);
        chk("R9 below page is ram", wr_addr[0], 16'hFEFE);
        chk("R9 below page data", ram[16'h7F7F], 16'hFFFB);
        chk("R9 page word untouched", ram[16'h7FFF], 16'h0000);
        chk("R8 low store", ram[2], 16'h001F);
    endtask

    task automatic t_load();
        prog.push_back(ri(4'hB, 1, 0, 4));
        prog.push_back(rr(4'h1, 2, 1, 1));
        prog.push_back(ri(4'h8, 3, 0, 20));
        prog.push_back(ri(4'h8, 4, 1, 17));
        prog.push_back(ri(4'h9, 3, 0, 22));
        prog.push_back(ri(4'h9, 4, 0, 25));
        prog.push_back(HLT);
        boot();
        ram[10] = 16'hA5C3;
        reset_cpu(); wait_halt("R8 load run");
        chk("R8 load then store", ram[11], 16'hA5C3);
        chk("R8 odd address aligned", ram[12], 16'hA5C3);
        chk("R8 flags kept", 16'(flags), 16'h2);
    endtask

    task automatic t_branch();
        prog.push_back(ri(4'hB, 1, 0, 1));
        prog.push_back(rr(4'h1, 2, 1, 1));
        prog.push_back(ri(4'hC, 0, 0, 1));
        prog.push_back(ri(4'hB, 3, 0, 7));
        prog.push_back(ri(4'hD, 0, 0, 1));
        prog.push_back(ri(4'hB, 4, 0, 9));
        prog.push_back(ri(4'hA, 0, 0, 1));
        prog.push_back(ri(4'hB, 5, 0, 3));
        prog.push_back(ri(4'h9, 3, 0, 30));
        prog.push_back(ri(4'h9, 4, 0, 28));
        prog.push_back(ri(4'h9, 5, 0, 26));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R10 branch run");
        chk("R10 jz taken skips", ram[15], 16'h0000);
        chk("R10 jnz falls through", ram[14], 16'h0009);
        chk("R10 jmp skips", ram[13], 16'h0000);
    endtask

    task automatic t_loop();
        prog.push_back(ri(4'hB, 1, 0, 3));
        prog.push_back(ri(4'hB, 2, 0, 1));
        prog.push_back(rr(4'h0, 3, 3, 2));
        prog.push_back(rr(4'h1, 1, 1, 2));
        prog.push_back(ri(4'hD, 0, 0, -3));
        prog.push_back(ri(4'h9, 3, 0, 2));
        prog.push_back(ri(4'h9, 1, 0, 4));
        prog.push_back(HLT);
        boot(); reset_cpu(); wait_halt("R10 loop run");
        chk("R10 backward jnz count", ram[1], 16'h0003);
        chk("R10 loop counter", ram[2], 16'h0000);
    endtask

    task automatic t_call();
        prog.push_back(ri(4'hB, 1, 0, 28));
        prog.push_back(rr(4'h6, 1, 1, 0));
        prog.push_back({4'hE, 3'd0, 3'd1, 6'd0});
        prog.push_back({4'hE, 3'd0, 3'd1, 6'd0});
        prog.push_back(ri(4'h9, 2, 0, 2));
        prog.push_back(HLT);
        for (int k = 0; k < 6; k++) prog.push_back(HLT);
        prog.push_back(ri(4'hB, 3, 0, 1));
        prog.push_back(rr(4'h0, 2, 2, 3));
        prog.push_back({4'hE, 9'd0, 3'd1});
        boot(); reset_cpu(); wait_halt("R11 call run");
        chk("R11 write count", 16'(wr_cnt), 16'd3);
        chk("R11 first push addr", wr_addr[0], 16'hFFFC);
        chk("R11 first return addr", wr_data[0], 16'h0026);
        chk("R11 second push addr", wr_addr[1], 16'hFFFC);
        chk("R11 second return addr", wr_data[1], 16'h0028);
        chk("R11 body ran twice", ram[1], 16'h0002);
        chk("R11 stack not io", 16'(ch_cnt), 16'd0);
    endtask

    task automatic t_halt();
        int r0, w0;
        prog.push_back(ri(4'hB, 1, 0, 5));
        prog.push_back(HLT);
        prog.push_back(ri(4'h9, 1, 0, 2));
        boot(); reset_cpu(); wait_halt("R12 halt run");
        r0 = rd_cnt; w0 = wr_cnt;
        repeat (12) @(negedge clk);
        chk("R12 halted stays", 16'(halted), 16'h1);
        chk("R12 no reads", 16'(rd_cnt - r0), 16'd0);
        chk("R12 no writes", 16'(wr_cnt - w0), 16'd0);
        chk("R12 later store not run", ram[1], 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ldi_add();
        t_sub_borrow();
        t_overflow();
        t_shift(1'b0);
        t_shift(1'b1);
        t_logic();
        t_mmio();
        t_load();
        t_branch();
        t_loop();
        t_call();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule